// File: doc/BRIEF.md
# Timer-Stamped Input Capture Channel

This block watches one external input signal and, when the chosen edge condition occurs, records the current value of one of two free-running 16-bit timer buses. Up to four records wait in a small first-in first-out store. Software reads them through a read strobe: the oldest record is always shown on the data output, and each read moves the other records one place forward.

The channel raises a sticky interrupt flag after a programmable number of stored captures. A separate strobe clears the flag. If the store is full and one more capture arrives, that capture is dropped, an overflow flag sets, and storing stays locked until the store has been read empty. A rising-edge wake mode writes nothing to the store and only raises the flag. A sleep input limits the channel to that wake mode. When an idle input and a stop-in-idle control are both set, the channel halts.

Top module: `stamp_capture`

## Requirements
- R1: The input passes through two synchronizer flops and an edge register. A capture therefore writes the timer value present at the third rising clock edge after the input changes. With `tmr_sel`=0 it stores `tmr_b`, and with `tmr_sel`=1 it stores `tmr_a`.
- R2: Records are read in arrival order. `rd_data` shows the oldest record. `not_empty` sets on the first capture and clears only after the last record has been read.
- R3: When four records are held and a capture arrives with no read in the same cycle, that capture is discarded and `overflow` sets.
- R4: While `overflow` is set, no capture is stored. `overflow` clears in the cycle the store becomes empty, and storing resumes after that.
- R5: A read strobe while the store is empty changes no state. `rd_data` is undefined in that case.
- R6: `mode` 3'b011 captures on rising edges, 3'b010 on falling edges, and 3'b001 on both edges.
- R7: `mode` 3'b100 captures on every 4th rising edge and 3'b101 on every 16th rising edge. The rising-edge count restarts from zero after the channel is disabled.
- R8: In `mode` 3'b001, `irq_flag` sets on every edge whatever the value of `evt_per_irq`. `overflow` never sets in this mode, and a capture that finds the store full is dropped silently.
- R9: In modes 3'b010 to 3'b101, `irq_flag` sets on every (`evt_per_irq`+1)-th stored capture. The flag stays set until `irq_clr` is pulsed. A new set in the same cycle as `irq_clr` takes priority.
- R10: `mode` 3'b111 sets `irq_flag` on each rising edge and stores nothing.
- R11: While `sleep` is 1, only `mode` 3'b111 acts. In every other mode, edges produce neither captures nor flags.
- R12: While `idle` and `stop_in_idle` are both 1, the channel ignores edges. With `stop_in_idle` at 0, the channel works fully in idle.
- R13: `mode` 3'b000 or 3'b110 disables the channel. In the next cycle the store, `overflow`, `irq_flag`, the event counter and the rising-edge count are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal being watched |
| tmr_a | input | 16 | First timer value |
| tmr_b | input | 16 | Second timer value (the one selected at reset) |
| tmr_sel | input | 1 | 1 selects `tmr_a`, 0 selects `tmr_b` |
| mode | input | 3 | Edge condition and enable (see R6, R7, R10, R13) |
| evt_per_irq | input | 2 | Stored captures per flag, minus one |
| sleep | input | 1 | Low-power sleep state |
| idle | input | 1 | Idle state |
| stop_in_idle | input | 1 | Halt the channel while idle |
| rd_stb | input | 1 | Pop the oldest record |
| rd_data | output | 16 | Oldest record |
| not_empty | output | 1 | Store holds at least one record |
| overflow | output | 1 | A capture was lost; storing is locked |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clears `irq_flag` |

## Verification
The assertions assume that `mode` is steady around each edge it qualifies. They also assume that `irq_clr` and `rd_stb` are single-cycle strobes driven on the same clock. The bench drives every input shortly after a rising clock edge. It returns `sig_in` low after each pulse, so each edge is counted once. Between tests it passes the channel through the disabled mode, so that the prescale and event counts start from known values.

// File: rtl/stamp_capture_pkg.sv
// Shared types for the timer-stamped capture channel.
// Assumes: mode encoding is fixed by the channel's programming model.
package stamp_capture_pkg;
    typedef enum logic [2:0] {
        M_OFF    = 3'b000,
        M_BOTH   = 3'b001,
        M_FALL   = 3'b010,
        M_RISE   = 3'b011,
        M_RISE4  = 3'b100,
        M_RISE16 = 3'b101,
        M_RSVD   = 3'b110,
        M_WAKE   = 3'b111
    } cap_mode_e;
endpackage

// File: rtl/edge_sync.sv
// Brings an asynchronous input into the clock domain and reports edges.
// Assumes: STAGES >= 2; edges are seen one cycle after the synchronized level.
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Compare the synchronized level with the previous one.
    always_comb begin
        rise = sync_q[STAGES-1] & ~last_q;
        fall = ~sync_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/cap_qualifier.sv
// Turns raw edges into capture and wake events according to the mode.
// Assumes: run already folds in the idle/stop condition; clear is the disabled state.
module cap_qualifier
    import stamp_capture_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cap_mode_e mode,
    input  logic      clear,
    input  logic      run,
    input  logic      sleep,
    input  logic      rise,
    input  logic      fall,
    output logic      cap_evt,
    output logic      wake_evt
);
    localparam logic [PRE_W-1:0] LIM4  = PRE_W'(3);
    localparam logic [PRE_W-1:0] LIM16 = PRE_W'(15);

    logic [PRE_W-1:0] pre_cnt;
    logic             live;
    logic             scaled;
    logic [PRE_W-1:0] limit;

    // Select the prescale limit and decide whether the channel may capture.
    always_comb begin
        live   = run & ~sleep & ~clear;
        scaled = (mode == M_RISE4) || (mode == M_RISE16);
        limit  = (mode == M_RISE4) ? LIM4 : LIM16;
    end

    // Count rising edges for the divide-by-4 and divide-by-16 modes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_cnt <= '0;
        end else if (live && scaled && rise) begin
            pre_cnt <= (pre_cnt >= limit) ? '0 : pre_cnt + 1'b1;
        end
    end

    // Decode the capture condition for the current mode.
    always_comb begin
        unique case (mode)
            M_BOTH:            cap_evt = live & (rise | fall);
            M_FALL:            cap_evt = live & fall;
            M_RISE:            cap_evt = live & rise;
            M_RISE4, M_RISE16: cap_evt = live & rise & (pre_cnt >= limit);
            default:           cap_evt = 1'b0;
        endcase
        wake_evt = (mode == M_WAKE) & rise & (run | sleep);
    end
endmodule

// File: rtl/stamp_fifo.sv
// Shifting store of capture records with overflow lock-out.
// Assumes: entry 0 is the oldest; a read in the same cycle frees room for a write.
module stamp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         allow_ovf,
    input  logic         rd_req,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         overflow,
    output logic         stored
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] wpos;
    logic          lock;
    logic          rd_ok;
    logic          space;
    logic          ovf_set;

    // Work out read, write and overflow for this cycle.
    always_comb begin
        rd_ok   = rd_req && (cnt != '0);
        space   = (cnt != CW'(DEPTH)) || rd_ok;
        stored  = wr_req && !lock && space;
        ovf_set = wr_req && !lock && !space && allow_ovf;
        wpos    = rd_ok ? cnt - 1'b1 : cnt;
        cnt_nxt = cnt + CW'(stored) - CW'(rd_ok);
    end

    // Each entry shifts forward on a read and takes new data at the write slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (stored && (wpos == CW'(i))) begin
                mem[i] <= wr_data;
            end else if (rd_ok) begin
                mem[i] <= (i < DEPTH - 1) ? mem[(i < DEPTH - 1) ? i + 1 : i] : mem[i];
            end
        end
    end

    // Track occupancy and the overflow lock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            lock <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (ovf_set) begin
                lock <= 1'b1;
            end else if (cnt_nxt == '0) begin
                lock <= 1'b0;
            end
        end
    end

    // Present the oldest record and the status.
    always_comb begin
        rd_data   = mem[0];
        not_empty = (cnt != '0);
        overflow  = lock;
    end
endmodule

// File: rtl/stamp_capture.sv
// Input capture channel: timestamps selected edges into a small store and
// raises a sticky interrupt flag after a programmed number of captures.
// Assumes: timers run freely outside; irq_clr and rd_stb are one-cycle strobes.
module stamp_capture
    import stamp_capture_pkg::*;
#(
    parameter int TW          = 16,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int EVT_W       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_in,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic          tmr_sel,
    input  logic [2:0]    mode,
    input  logic [EVT_W-1:0] evt_per_irq,
    input  logic          sleep,
    input  logic          idle,
    input  logic          stop_in_idle,
    input  logic          rd_stb,
    output logic [TW-1:0] rd_data,
    output logic          not_empty,
    output logic          overflow,
    output logic          irq_flag,
    input  logic          irq_clr
);
    cap_mode_e        mode_e;
    logic             disabled;
    logic             run;
    logic             rise;
    logic             fall;
    logic             cap_evt;
    logic             wake_evt;
    logic             stored;
    logic             irq_set;
    logic [EVT_W-1:0] evt_cnt;
    logic [TW-1:0]    stamp;

    // Decode enable and halt conditions and pick the timer.
    always_comb begin
        mode_e   = cap_mode_e'(mode);
        disabled = (mode_e == M_OFF) || (mode_e == M_RSVD);
        run      = !(idle && stop_in_idle);
        stamp    = tmr_sel ? tmr_a : tmr_b;
    end

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise),
        .fall     (fall)
    );

    cap_qualifier #(.PRE_W(4)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .clear    (disabled),
        .run      (run),
        .sleep    (sleep),
        .rise     (rise),
        .fall     (fall),
        .cap_evt  (cap_evt),
        .wake_evt (wake_evt)
    );

    stamp_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (disabled),
        .wr_req    (cap_evt),
        .wr_data   (stamp),
        .allow_ovf (mode_e != M_BOTH),
        .rd_req    (rd_stb),
        .rd_data   (rd_data),
        .not_empty (not_empty),
        .overflow  (overflow),
        .stored    (stored)
    );

    // Decide whether this cycle raises the interrupt flag.
    always_comb begin
        if (mode_e == M_BOTH) begin
            irq_set = cap_evt;
        end else begin
            irq_set = wake_evt || (stored && (evt_cnt == evt_per_irq));
        end
    end

    // Count stored captures between flag assertions.
    always_ff @(posedge clk) begin
        if (!rst_n || disabled) begin
            evt_cnt <= '0;
        end else if (stored && mode_e != M_BOTH) begin
            evt_cnt <= (evt_cnt == evt_per_irq) ? '0 : evt_cnt + 1'b1;
        end
    end

    // Sticky interrupt flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || disabled) begin
            irq_flag <= 1'b0;
        end else if (irq_set) begin
            irq_flag <= 1'b1;
        end else if (irq_clr) begin
            irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/stamp_capture_chk.sv
// Property checker for stamp_capture, bound to every instance.
// Assumes: observes only ports of the top module.
module stamp_capture_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       sleep,
    input logic       irq_clr,
    input logic       not_empty,
    input logic       overflow,
    input logic       irq_flag
);
    logic dis;
    assign dis = (mode == 3'b000) || (mode == 3'b110);

    // R3: an overflow is only possible with records held
    a_r3_ovf_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> not_empty);

    // R4: the overflow lock holds while records remain
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !dis) |=> (overflow || !not_empty));

    // R8: every-edge mode never raises overflow
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001 && !overflow) |=> !overflow);

    // R9: the flag stays until cleared
    a_r9_sticky_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr && !dis) |=> irq_flag);

    // R11: in sleep nothing is stored outside wake mode
    a_r11_sleep_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && mode != 3'b111 && !not_empty && !dis) |=> !not_empty);

    // R13: disabling clears store and flags
    a_r13_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (!not_empty && !overflow && !irq_flag));
endmodule

bind stamp_capture stamp_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .sleep     (sleep),
    .irq_clr   (irq_clr),
    .not_empty (not_empty),
    .overflow  (overflow),
    .irq_flag  (irq_flag)
);

// File: tb/stamp_capture_bench.sv
// Scoreboard bench: drivers queue expected records, a monitor compares reads.
module stamp_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic [15:0] tmr_a = '0;
    logic [15:0] tmr_b = '0;
    logic        tmr_sel = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [1:0]  evt_per_irq = 2'd0;
    logic        sleep = 1'b0;
    logic        idle = 1'b0;
    logic        stop_in_idle = 1'b0;
    logic        rd_stb = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] rd_data;
    logic        not_empty;
    logic        overflow;
    logic        irq_flag;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    stamp_capture u_stamp_capture (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .tmr_sel(tmr_sel), .mode(mode), .evt_per_irq(evt_per_irq), .sleep(sleep),
        .idle(idle), .stop_in_idle(stop_in_idle), .rd_stb(rd_stb), .rd_data(rd_data),
        .not_empty(not_empty), .overflow(overflow), .irq_flag(irq_flag), .irq_clr(irq_clr)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse();
        sig_in = 1'b1;
        tick(4);
        sig_in = 1'b0;
        tick(4);
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode = m;
        tick(1);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
    endtask

    task automatic drain(input string req);
        while (not_empty) begin
            rd_stb = 1'b1;
            tick(1);
            rd_stb = 1'b0;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // Monitor: compares each read against the head of the scoreboard queue (R2).
    always @(negedge clk) begin
        if (rd_stb && not_empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected record", rd_data, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2 record order/value", rd_data, e);
            end
        end
    end

    initial begin : watchdog
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(!not_empty && !overflow && !irq_flag, "R13 reset state",
              {not_empty, overflow, irq_flag}, 0);

        // R1 timer select and latency, R9 one capture per flag
        set_mode(3'b011);
        tmr_a = 16'hAAAA; tmr_b = 16'h1111;
        sig_in = 1'b1;
        tick(2);
        check(!not_empty, "R1 no capture before third edge", not_empty, 0);
        tick(1);
        check(not_empty, "R1 capture at third edge", not_empty, 1);
        exp_q.push_back(16'h1111);
        sig_in = 1'b0; tick(4);
        check(irq_flag, "R9 flag after one capture", irq_flag, 1);
        tmr_sel = 1'b1; tmr_a = 16'hA5A5;
        pulse(); exp_q.push_back(16'hA5A5);
        tmr_sel = 1'b0;
        drain("R2 drain in order");
        check(!not_empty, "R2 empty after drain", not_empty, 0);

        // R5 empty read changes nothing
        rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
        check(!not_empty && !overflow, "R5 empty read", {not_empty, overflow}, 0);
        tmr_b = 16'h0BEE; pulse(); exp_q.push_back(16'h0BEE);
        drain("R5 store intact after empty read");

        // R3 overflow and R4 lock-out
        for (int k = 0; k < 5; k++) begin
            tmr_b = 16'h2000 + 16'(k);
            pulse();
            if (k < 4) exp_q.push_back(16'h2000 + 16'(k));
        end
        check(overflow, "R3 fifth capture overflows", overflow, 1);
        rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
        tmr_b = 16'h2100; pulse();
        check(overflow, "R4 lock held after partial read", overflow, 1);
        drain("R4 locked capture discarded");
        check(!overflow, "R4 overflow clears when empty", overflow, 0);
        tmr_b = 16'h2200; pulse(); exp_q.push_back(16'h2200);
        check(not_empty, "R4 storing resumes", not_empty, 1);
        drain("R4 resumed record");

        // R6 falling edge mode
        set_mode(3'b000); set_mode(3'b010);
        tmr_b = 16'h3030;
        sig_in = 1'b1; tick(4);
        check(!not_empty, "R6 falling mode ignores rise", not_empty, 0);
        sig_in = 1'b0; tick(4);
        check(not_empty, "R6 falling mode captures fall", not_empty, 1);
        exp_q.push_back(16'h3030);
        drain("R6 falling record");

        // R7 divide by 4 and by 16
        set_mode(3'b000); set_mode(3'b100);
        tmr_b = 16'h4444;
        for (int k = 0; k < 3; k++) pulse();
        check(!not_empty, "R7 no capture before 4th rise", not_empty, 0);
        pulse(); exp_q.push_back(16'h4444);
        check(not_empty, "R7 capture on 4th rise", not_empty, 1);
        drain("R7 div4 record");
        set_mode(3'b000); set_mode(3'b101);
        tmr_b = 16'h1616;
        for (int k = 0; k < 15; k++) pulse();
        check(!not_empty, "R7 no capture before 16th rise", not_empty, 0);
        pulse(); exp_q.push_back(16'h1616);
        check(not_empty, "R7 capture on 16th rise", not_empty, 1);
        drain("R7 div16 record");

        // R8 every edge: flag per edge, divider ignored, no overflow
        set_mode(3'b000); set_mode(3'b001);
        evt_per_irq = 2'd3;
        tmr_b = 16'h5000;
        sig_in = 1'b1; tick(4);
        check(irq_flag, "R8 flag on rise", irq_flag, 1);
        clear_irq();
        sig_in = 1'b0; tick(4);
        check(irq_flag, "R8 flag on fall", irq_flag, 1);
        exp_q.push_back(16'h5000); exp_q.push_back(16'h5000);
        for (int k = 0; k < 2; k++) pulse();
        exp_q.push_back(16'h5000); exp_q.push_back(16'h5000);
        check(!overflow, "R8 no overflow when full", overflow, 0);
        drain("R8 four records kept");

        // R9 three captures per flag
        set_mode(3'b000); set_mode(3'b011);
        evt_per_irq = 2'd2;
        tmr_b = 16'h6000;
        pulse(); pulse();
        check(!irq_flag, "R9 no flag after two", irq_flag, 0);
        pulse();
        check(irq_flag, "R9 flag after three", irq_flag, 1);
        tick(3);
        check(irq_flag, "R9 flag sticky", irq_flag, 1);
        clear_irq();
        check(!irq_flag, "R9 flag cleared", irq_flag, 0);
        repeat (3) exp_q.push_back(16'h6000);
        drain("R9 records");
        evt_per_irq = 2'd0;

        // R10 wake mode
        set_mode(3'b000); set_mode(3'b111);
        pulse();
        check(irq_flag && !not_empty, "R10 wake flag without store",
              {irq_flag, not_empty}, 2);

        // R11 sleep
        set_mode(3'b000); set_mode(3'b011);
        sleep = 1'b1;
        pulse();
        check(!irq_flag && !not_empty, "R11 sleep blocks rise mode",
              {irq_flag, not_empty}, 0);
        set_mode(3'b111);
        pulse();
        check(irq_flag, "R11 wake works in sleep", irq_flag, 1);
        sleep = 1'b0;

        // R12 idle
        set_mode(3'b000); set_mode(3'b011);
        idle = 1'b1; stop_in_idle = 1'b1;
        pulse();
        check(!not_empty, "R12 halted in idle", not_empty, 0);
        stop_in_idle = 1'b0;
        tmr_b = 16'h7777; pulse(); exp_q.push_back(16'h7777);
        check(not_empty, "R12 runs in idle", not_empty, 1);
        drain("R12 idle record");
        idle = 1'b0;

        // R13 disable clears
        tmr_b = 16'h8888; pulse(); pulse();
        set_mode(3'b110);
        check(!not_empty && !irq_flag && !overflow, "R13 reserved mode clears",
              {not_empty, overflow, irq_flag}, 0);
        exp_q.delete();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule